// File: doc/BRIEF.md
# Cascaded Serial Display Loader

This block drives a daisy chain of serial-input latched display drivers. A caller presents a parallel frame word and pulses a start strobe. The loader then produces the serial data line, the shift clock and the latch enable for the chain. All three are timed from the fast system clock by cycle-count parameters, so every edge meets the drivers' minimum setup, hold, clock-high, clock-to-latch and latch-width times. A blanking request passes through a register to the chain's blanking line.

The chain holds `DEVICES*CHANNELS` bits. The bit meant for the final stage of the final device goes out first. After the last shift, each frame bit therefore sits at its own stage. Frame bit `d*CHANNELS + c` lands on device `d` (device 0 is nearest the loader), stage `c+1`. From reset onward every driver input sits at a defined idle level: data low, clock low, latch enable low and blanking high. `busy` covers the whole transfer and `done` marks its end.

Top module: `serial_frame_loader`

## Requirements
- R1: While reset is high and after it is released, `drv_data`, `drv_clk`, `drv_le`, `busy` and `done` are 0 and `drv_blank` is 1.
- R2: After a frame completes, device `d` stage `c+1` of the chain holds `frame[d*CHANNELS+c]`. `frame[DEVICES*CHANNELS-1]` is the first bit driven on `drv_data`.
- R3: Each frame produces exactly `DEVICES*CHANNELS` rising edges of `drv_clk` before `drv_le` rises.
- R4: `drv_data` holds its value for at least `SETUP_CYC` cycles before each rising edge of `drv_clk`. It does not change while `drv_clk` is high or in the cycle it falls.
- R5: `drv_clk` stays high exactly `HIGH_CYC` cycles. It then stays low for `LOW_EFF = max(LOW_CYC, HOLD_CYC-HIGH_CYC)` cycles before the data line moves, so data is held `HIGH_CYC+LOW_EFF >= HOLD_CYC` cycles after each rising edge.
- R6: `drv_le` rises `HIGH_CYC+LOW_EFF+LATCH_DLY_CYC` cycles after the last rising edge of `drv_clk`. It stays high exactly `LATCH_W_CYC` cycles and is never high together with `drv_clk`.
- R7: `busy` rises in the cycle after an accepted start and stays high for `DEVICES*CHANNELS*(SETUP_CYC+HIGH_CYC+LOW_EFF)+LATCH_DLY_CYC+LATCH_W_CYC` cycles. `done` is a one-cycle pulse in the first cycle with `busy` low.
- R8: A start while `busy` is high is ignored. The frame in flight and its duration are unchanged, whatever `frame` carries at that time.
- R9: `drv_blank` equals `blank_req` delayed by one cycle, in every loader state. The chain outputs read all low while it is high.
- R10: A start presented in the cycle where `done` is high is accepted: `busy` rises on the next cycle and the new frame is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send `frame` (honoured only while not busy) |
| frame | input | DEVICES*CHANNELS | Parallel frame word, bit `d*CHANNELS+c` for device `d` stage `c+1` |
| blank_req | input | 1 | Blanking request forwarded to the chain |
| drv_data | output | 1 | Serial data to the first device |
| drv_clk | output | 1 | Shift clock to all devices |
| drv_le | output | 1 | Latch enable to all devices |
| drv_blank | output | 1 | Blanking line to all devices |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A start request can coincide with the end of a transfer. The bench presents a new frame and start exactly in the cycle where `done` is sampled high, and expects `busy` back on the next cycle with the second frame intact in the chain. It also raises start repeatedly mid-transfer with the inverted word on `frame`, and judges that the chain ends holding the original word and that `busy` lasted the nominal count. Blanking is toggled while a latched frame is present, and the chain outputs are compared against zero and then against the restored frame.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLK_HIGH,
    ST_CLK_LOW,
    ST_LE_DELAY,
    ST_LE_HIGH,
    ST_DONE
  } sfl_state_t;
endpackage

// File: rtl/sfl_countdown.sv
module sfl_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // a nonzero load must leave at least one further cycle in the phase (R5)
  assert_phase_len_R5: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/sfl_frame_shift.sv
module sfl_frame_shift #(
  parameter int TOTAL = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [TOTAL-1:0] frame,
  output logic             ser
);
  logic [TOTAL-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= frame;
    end else if (shift) begin
      sr <= {sr[TOTAL-2:0], 1'b0};
    end
  end

  // highest index leaves first: it travels to the far end of the chain (R2)
  assign ser = sr[TOTAL-1];
endmodule

// File: rtl/sfl_sequencer.sv
module sfl_sequencer
  import sfl_pkg::*;
#(
  parameter int TOTAL     = 20,
  parameter int CW        = 8,
  parameter int SETUP_CYC = 13,
  parameter int HIGH_CYC  = 25,
  parameter int LOW_EFF   = 25,
  parameter int LD_CYC    = 13,
  parameter int LW_CYC    = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          expired,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          sr_load,
  output logic          sr_shift,
  output logic          sclk,
  output logic          latch,
  output logic          busy,
  output logic          done
);
  localparam int BW = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(TOTAL - 1);

  sfl_state_t    state;
  logic [BW-1:0] bit_idx;
  logic          accept;
  logic          last_bit;

  assign accept   = start && (state == ST_IDLE || state == ST_DONE);
  assign last_bit = (bit_idx == LAST_IDX);

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    sr_load  = accept;
    sr_shift = (state == ST_CLK_LOW) && expired;
    if (accept) begin
      cnt_load = 1'b1;
      cnt_val  = CW'(SETUP_CYC - 1);
    end else if (expired) begin
      case (state)
        ST_SETUP: begin
          cnt_load = 1'b1;
          cnt_val  = CW'(HIGH_CYC - 1);
        end
        ST_CLK_HIGH: begin
          cnt_load = 1'b1;
          cnt_val  = CW'(LOW_EFF - 1);
        end
        ST_CLK_LOW: begin
          cnt_load = 1'b1;
          cnt_val  = last_bit ? CW'(LD_CYC - 1) : CW'(SETUP_CYC - 1);
        end
        ST_LE_DELAY: begin
          cnt_load = 1'b1;
          cnt_val  = CW'(LW_CYC - 1);
        end
        default: begin
          cnt_load = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      sclk    <= 1'b0;
      latch   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_SETUP;
            busy    <= 1'b1;
            bit_idx <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_SETUP: if (expired) begin
          state <= ST_CLK_HIGH;
          sclk  <= 1'b1;
        end
        ST_CLK_HIGH: if (expired) begin
          state <= ST_CLK_LOW;
          sclk  <= 1'b0;
        end
        ST_CLK_LOW: if (expired) begin
          if (last_bit) begin
            state <= ST_LE_DELAY;
          end else begin
            state   <= ST_SETUP;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_LE_DELAY: if (expired) begin
          state <= ST_LE_HIGH;
          latch <= 1'b1;
        end
        ST_LE_HIGH: if (expired) begin
          state <= ST_DONE;
          latch <= 1'b0;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_le_clk_apart_R6: assert property (@(posedge clk) disable iff (rst)
    latch |-> !sclk);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_on_start_R10: assert property (@(posedge clk) disable iff (rst)
    sr_load |=> busy);
endmodule

// File: rtl/serial_frame_loader.sv
module serial_frame_loader #(
  parameter int DEVICES       = 2,
  parameter int CHANNELS      = 10,
  parameter int SETUP_CYC     = 13,
  parameter int HIGH_CYC      = 25,
  parameter int LOW_CYC       = 25,
  parameter int HOLD_CYC      = 13,
  parameter int LATCH_DLY_CYC = 13,
  parameter int LATCH_W_CYC   = 25
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [DEVICES*CHANNELS-1:0]  frame,
  input  logic                         blank_req,
  output logic                         drv_data,
  output logic                         drv_clk,
  output logic                         drv_le,
  output logic                         drv_blank,
  output logic                         busy,
  output logic                         done
);
  localparam int TOTAL    = DEVICES * CHANNELS;
  localparam int HOLD_REM = (HOLD_CYC > HIGH_CYC) ? (HOLD_CYC - HIGH_CYC) : 0;
  localparam int LOW_EFF  = (LOW_CYC > HOLD_REM) ? LOW_CYC : HOLD_REM;
  localparam int M1       = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int M2       = (LOW_EFF > LATCH_DLY_CYC) ? LOW_EFF : LATCH_DLY_CYC;
  localparam int M3       = (M1 > M2) ? M1 : M2;
  localparam int MAXV     = (M3 > LATCH_W_CYC) ? M3 : LATCH_W_CYC;
  localparam int CW       = $clog2(MAXV + 1);
  localparam int RW       = $clog2(TOTAL + 1) + 1;

  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          expired;
  logic          sr_load;
  logic          sr_shift;

  sfl_countdown #(.W(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expired  (expired)
  );

  sfl_frame_shift #(.TOTAL(TOTAL)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (sr_load),
    .shift (sr_shift),
    .frame (frame),
    .ser   (drv_data)
  );

  sfl_sequencer #(
    .TOTAL     (TOTAL),
    .CW        (CW),
    .SETUP_CYC (SETUP_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .LOW_EFF   (LOW_EFF),
    .LD_CYC    (LATCH_DLY_CYC),
    .LW_CYC    (LATCH_W_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .expired  (expired),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .sr_load  (sr_load),
    .sr_shift (sr_shift),
    .sclk     (drv_clk),
    .latch    (drv_le),
    .busy     (busy),
    .done     (done)
  );

  // blanking is a plain registered pass-through, high (outputs off) from reset
  always_ff @(posedge clk) begin
    if (rst) drv_blank <= 1'b1;
    else     drv_blank <= blank_req;
  end

  // ---- timing observers for the assertions below ----
  localparam logic [CW:0] SETUP_MIN = (CW+1)'(SETUP_CYC - 1);
  localparam logic [CW:0] HIGH_V    = (CW+1)'(HIGH_CYC);
  localparam logic [CW:0] LW_V      = (CW+1)'(LATCH_W_CYC);
  localparam logic [RW-1:0] TOTAL_V = RW'(TOTAL);

  logic          data_q, clk_q;
  logic [CW:0]   age_q, hi_q, le_q;
  logic [RW-1:0] rises_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= 1'b0;
      clk_q   <= 1'b0;
      age_q   <= '0;
      hi_q    <= '0;
      le_q    <= '0;
      rises_q <= '0;
    end else begin
      data_q <= drv_data;
      clk_q  <= drv_clk;
      if (drv_data != data_q)   age_q <= '0;
      else if (age_q != '1)     age_q <= age_q + 1'b1;
      hi_q <= drv_clk ? hi_q + 1'b1 : '0;
      le_q <= drv_le  ? le_q + 1'b1 : '0;
      if (sr_load)                rises_q <= '0;
      else if (drv_clk && !clk_q) rises_q <= rises_q + 1'b1;
    end
  end

  assert_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_clk) |-> (drv_data == data_q) && (age_q >= SETUP_MIN));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    drv_clk |-> (drv_data == data_q));
  assert_clk_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_clk) |-> (hi_q == HIGH_V));
  assert_le_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_le) |-> (le_q == LW_V));
  assert_edge_count_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_le) |-> (rises_q == TOTAL_V));
  assert_no_reload_R8: assert property (@(posedge clk) disable iff (rst)
    sr_load |-> !busy);
  assert_blank_follow_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (drv_blank == $past(blank_req)));
endmodule

// File: tb/serial_frame_loader_test.sv
module sfl_driver_model #(
  parameter int CH = 4
) (
  input  logic          sclk,
  input  logic          din,
  input  logic          le,
  input  logic          blank,
  output logic          dout,
  output logic [CH-1:0] q
);
  logic [CH-1:0] sr = '0;
  logic [CH-1:0] lat = '0;
  always @(posedge sclk) sr <= {sr[CH-2:0], din};
  always @* if (le) lat = sr;
  assign dout = sr[CH-1];
  assign q    = blank ? '0 : lat;
endmodule

module serial_frame_loader_test;
  localparam int DEV = 2, CH = 4, TOT = DEV * CH;
  localparam int TS = 2, TH = 3, TL = 2, THOLD = 6, TLD = 2, TLW = 3;
  localparam int HREM   = (THOLD > TH) ? THOLD - TH : 0;
  localparam int LEFF   = (TL > HREM) ? TL : HREM;
  localparam int BUSY_N = TOT * (TS + TH + LEFF) + TLD + TLW;
  localparam int TO_LE  = TH + LEFF + TLD;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, blank_req = 1'b0;
  logic [TOT-1:0] frame = '0;
  logic drv_data, drv_clk, drv_le, drv_blank, busy, done;
  logic d0_out, d1_out;
  logic [CH-1:0] q0, q1;
  logic [TOT-1:0] chain_q;

  always #2 clk = ~clk;

  serial_frame_loader #(
    .DEVICES(DEV), .CHANNELS(CH), .SETUP_CYC(TS), .HIGH_CYC(TH), .LOW_CYC(TL),
    .HOLD_CYC(THOLD), .LATCH_DLY_CYC(TLD), .LATCH_W_CYC(TLW)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .frame(frame), .blank_req(blank_req),
    .drv_data(drv_data), .drv_clk(drv_clk), .drv_le(drv_le), .drv_blank(drv_blank),
    .busy(busy), .done(done)
  );

  sfl_driver_model #(.CH(CH)) dev0 (.sclk(drv_clk), .din(drv_data), .le(drv_le),
    .blank(drv_blank), .dout(d0_out), .q(q0));
  sfl_driver_model #(.CH(CH)) dev1 (.sclk(drv_clk), .din(d0_out), .le(drv_le),
    .blank(drv_blank), .dout(d1_out), .q(q1));
  assign chain_q = {q1, q0};

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rises, setup_bad, hold_bad, hi_bad, rises_at_le, to_latch, le_len, overlap;
  int busy_len, done_cnt, done_busy, age, hi, le_hi, since_rise;
  logic p_clk = 1'b0, p_data = 1'b0, p_le = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    rises = 0; setup_bad = 0; hold_bad = 0; hi_bad = 0; rises_at_le = -1;
    to_latch = -1; le_len = -1; overlap = 0; busy_len = 0; done_cnt = 0;
    done_busy = 0; since_rise = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (drv_clk && !p_clk) begin
        rises++;
        if (age < TS) setup_bad++;
        since_rise = 0;
      end else begin
        since_rise++;
      end
      if (drv_data !== p_data && (drv_clk || p_clk)) hold_bad++;
      if (!drv_clk && p_clk && hi != TH) hi_bad++;
      if (drv_le && !p_le) begin rises_at_le = rises; to_latch = since_rise; end
      if (!drv_le && p_le) le_len = le_hi;
      if (drv_le && drv_clk) overlap++;
      if (busy) busy_len++;
      if (done) begin done_cnt++; if (busy) done_busy++; end
      age   = (drv_data !== p_data) ? 1 : age + 1;
      hi    = drv_clk ? hi + 1 : 0;
      le_hi = drv_le ? le_hi + 1 : 0;
    end
    p_clk = drv_clk; p_data = drv_data; p_le = drv_le;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  task automatic launch(input logic [TOT-1:0] f);
    @(negedge clk);
    clear_stats();
    frame = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic frame_checks(input logic [TOT-1:0] f);
    check(chain_q == f, "R2 chain contents", int'(chain_q), int'(f));
    check(rises == TOT && rises_at_le == TOT, "R3 shift edges", rises_at_le, TOT);
    check(setup_bad == 0 && hold_bad == 0, "R4 setup/hold", setup_bad + hold_bad, 0);
    check(hi_bad == 0, "R5 clock high width", hi_bad, 0);
    check(le_len == TLW && to_latch == TO_LE && overlap == 0, "R6 latch pulse",
          le_len * 100 + to_latch, TLW * 100 + TO_LE);
    check(busy_len == BUSY_N, "R7 busy length", busy_len, BUSY_N);
    check(done_cnt == 1 && done_busy == 0, "R7 done pulse", done_cnt, 1);
  endtask

  initial begin
    clear_stats();
    age = 0; hi = 0; le_hi = 0;
    repeat (3) @(negedge clk);
    // R1: idle levels during reset
    check({drv_data, drv_clk, drv_le, drv_blank, busy, done} == 6'b000100,
          "R1 reset levels", {drv_data, drv_clk, drv_le, drv_blank, busy, done}, 6'b000100);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check({drv_data, drv_clk, drv_le, busy, done} == 5'b00000, "R1 after release",
          {drv_data, drv_clk, drv_le, busy, done}, 0);

    // R2..R7: every frame value of the small chain
    for (int v = 0; v < (1 << TOT); v++) begin
      launch(TOT'(v));
      wait_done();
      @(negedge clk);
      frame_checks(TOT'(v));
    end

    // R9: blanking forces outputs low and releases them again
    blank_req = 1'b1;
    @(negedge clk);
    check(drv_blank == 1'b1 && chain_q == '0, "R9 blank on", int'(chain_q), 0);
    blank_req = 1'b0;
    @(negedge clk);
    check(drv_blank == 1'b0 && chain_q == TOT'((1 << TOT) - 1), "R9 blank off",
          int'(chain_q), (1 << TOT) - 1);

    // R8: start with another word while busy has no effect
    launch(TOT'(8'hA5));
    repeat (10) @(negedge clk);
    frame = ~TOT'(8'hA5); start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_done();
    @(negedge clk);
    check(chain_q == TOT'(8'hA5), "R8 frame kept", int'(chain_q), 8'hA5);
    check(busy_len == BUSY_N, "R8 duration kept", busy_len, BUSY_N);

    // R10: start in the done cycle is accepted
    launch(TOT'(8'h3C));
    wait_done();
    clear_stats();
    frame = TOT'(8'hC3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after done-cycle start", busy, 1);
    wait_done();
    @(negedge clk);
    check(chain_q == TOT'(8'hC3), "R10 second frame", int'(chain_q), 8'hC3);

    finish_run();
  end
endmodule